// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This engine sits on the DMA side of a network receive path. It moves incoming frames into host memory buffers. Software describes those buffers with a chain of descriptors kept in a shared memory. Each descriptor is four 32-bit words, and an ownership flag says which side may touch it.

For each frame the engine works through the same steps:
- It fetches the current descriptor and confirms that the descriptor is handed over.
- It stores the frame one byte at a time into the described buffer.
- It writes back a packed status word carrying the length, the address class and the error causes. Ownership goes back to software at this point.
- It follows the branch pointer to the next descriptor.

When the chain runs dry, the engine raises a no-buffer interrupt. It then holds off the frame source until software issues a poll strobe.

Software starts the engine by loading a descriptor address. The memory port is single-cycle: a read returns data in the cycle after the request. Writes carry byte enables.

Top module: `rxd_ring_writer`

## Requirements
- R1: After reset the engine issues no memory request, raises no interrupt and keeps `fr_ready` low. It stays in that state until `desc_load` supplies a descriptor address.
- R2: A descriptor holds four words at byte offsets +0 status, +4 control, +8 buffer address and +12 branch address. After a frame's status write-back, the engine continues at the descriptor named by the branch word.
- R3: A descriptor is used only when status bit 31 is set. Otherwise the engine pulses `irq_nobuf` and keeps `fr_ready` low. It reads the status word again only after a `poll` strobe.
- R4: Frame byte k goes to byte address buffer+k, for any alignment of the buffer. The write uses a word-aligned `mem_addr`, a single enabled lane equal to the low two address bits, and the byte replicated on all lanes of `mem_wdata`.
- R5: The status word written back has:
  - bit 31 cleared;
  - bits 26:16 holding the stored length, which includes the 4-byte FCS;
  - bits 9 (first buffer) and 8 (last buffer) both set;
  - bit 15 set only for an error-free frame;
  - the class taken from `fr_cls` on the end beat: 1 sets bit 11 (unicast), 2 sets bit 12 (broadcast), 3 sets bit 13 (multicast), 0 sets none.
  - Bits 7, 6 and 14 are always zero.
- R6: `fr_err` is sampled on the end beat and mapped as follows: bit 0 to status bit 1 (CRC), bit 1 to bit 2 (alignment), bit 2 to bit 3 (FIFO overflow), bit 3 to bit 5 (runt). Status bit 0 is the OR of all error bits.
- R7: The buffer size is control bits 10:0. Bytes beyond it are accepted but not written. The length field then reports the size, and bits 4 (long) and 0 are set.
- R8: The status word is written as one full-word write to the descriptor's own address. It comes after the last data byte, in the same cycle as the completion interrupt.
- R9: Each finished frame pulses exactly one of `irq_done` (no error bit set) or `irq_err` for one cycle. At most one interrupt output is high in any cycle.
- R10: A branch word of zero ends the chain. The engine pulses `irq_nobuf`, and each `poll` re-reads the branch word until that word is nonzero.
- R11: Beats offered before the first beat with `fr_sof` are consumed and discarded. They write nothing and add nothing to the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_load | input | 1 | Load `desc_addr` as the current descriptor (honoured while idle or stalled) |
| desc_addr | input | AW | Descriptor byte address to load |
| poll | input | 1 | Receive poll demand strobe |
| fr_valid | input | 1 | Frame beat valid |
| fr_ready | output | 1 | Engine accepts a beat |
| fr_data | input | 8 | Frame byte |
| fr_sof | input | 1 | First byte of a frame |
| fr_eof | input | 1 | Last byte of a frame |
| fr_err | input | 4 | Error causes, valid on the end beat |
| fr_cls | input | 2 | Address class, valid on the end beat |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Word-aligned byte address |
| mem_be | output | 4 | Byte-lane enables for writes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |
| irq_done | output | 1 | Frame stored without error |
| irq_err | output | 1 | Frame stored with error flags |
| irq_nobuf | output | 1 | No usable descriptor; engine stalled |

## Verification
The hardest situations to reach are the two stall paths. An unowned descriptor and a zero branch are both found only after a frame has finished and its status has been written. Recovery from each also depends on a memory change followed by a poll. The stimulus first runs randomized frames through a linear chain. It then ends the chain on a descriptor left unowned, holds a pending frame against the stall, and only then arms that descriptor and polls. That descriptor's own branch is zero, so the second stall follows right away. The bench then patches the branch word and polls again. Truncation, pre-start junk and an odd buffer address are placed on dedicated descriptors along the way.

// File: rtl/rxd_pkg.sv
package rxd_pkg;

    typedef enum logic [3:0] {
        ST_HALT,
        ST_RD_STAT,
        ST_CHK_OWN,
        ST_CAP_CTL,
        ST_CAP_BUF,
        ST_CAP_BR,
        ST_DATA,
        ST_WB,
        ST_NEXT,
        ST_WAIT_POLL,
        ST_WAIT_LINK,
        ST_CHK_LINK
    } rxd_state_e;

    // status word layout
    localparam int OWN_BIT   = 31;
    localparam int LEN_LSB   = 16;
    localparam int LEN_W     = 11;
    localparam int OK_BIT    = 15;
    localparam int MC_BIT    = 13;
    localparam int BC_BIT    = 12;
    localparam int UC_BIT    = 11;
    localparam int FIRST_BIT = 9;
    localparam int LAST_BIT  = 8;
    localparam int RUNT_BIT  = 5;
    localparam int LONG_BIT  = 4;
    localparam int OVF_BIT   = 3;
    localparam int ALN_BIT   = 2;
    localparam int CRC_BIT   = 1;
    localparam int SUM_BIT   = 0;

    // descriptor word offsets
    localparam int OFS_CTL = 4;
    localparam int OFS_BUF = 8;
    localparam int OFS_BR  = 12;

endpackage

// File: rtl/rxd_status_pack.sv
module rxd_status_pack
    import rxd_pkg::*;
(
    input  logic [LEN_W:0]   cnt,
    input  logic [LEN_W-1:0] size,
    input  logic             lng,
    input  logic [3:0]       errs,
    input  logic [1:0]       cls,
    output logic [31:0]      word
);
    logic any_err;

    always_comb begin
        any_err = (|errs) | lng;
        word = '0;
        word[LEN_LSB +: LEN_W] = lng ? size : cnt[LEN_W-1:0];
        word[CRC_BIT]   = errs[0];
        word[ALN_BIT]   = errs[1];
        word[OVF_BIT]   = errs[2];
        word[RUNT_BIT]  = errs[3];
        word[LONG_BIT]  = lng;
        word[SUM_BIT]   = any_err;
        word[OK_BIT]    = ~any_err;
        word[FIRST_BIT] = 1'b1;
        word[LAST_BIT]  = 1'b1;
        case (cls)
            2'd1:    word[UC_BIT] = 1'b1;
            2'd2:    word[BC_BIT] = 1'b1;
            2'd3:    word[MC_BIT] = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/rxd_byte_lane.sv
module rxd_byte_lane #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    input  logic [7:0]    data,
    output logic [AW-1:0] addr,
    output logic [3:0]    be,
    output logic [31:0]   wdata
);
    logic [AW-1:0] byte_addr;

    always_comb begin
        byte_addr = base + offset;
        addr      = {byte_addr[AW-1:2], 2'b00};
        be        = 4'b0001 << byte_addr[1:0];
        wdata     = {4{data}};
    end
endmodule

// File: rtl/rxd_ring_writer.sv
module rxd_ring_writer
    import rxd_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          desc_load,
    input  logic [AW-1:0] desc_addr,
    input  logic          poll,
    input  logic          fr_valid,
    output logic          fr_ready,
    input  logic [7:0]    fr_data,
    input  logic          fr_sof,
    input  logic          fr_eof,
    input  logic [3:0]    fr_err,
    input  logic [1:0]    fr_cls,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          irq_done,
    output logic          irq_err,
    output logic          irq_nobuf
);
    localparam int CW = LEN_W + 1;

    typedef struct packed {
        rxd_state_e     st;
        logic [AW-1:0]  cur;
        logic [AW-1:0]  bufa;
        logic [AW-1:0]  br;
        logic [LEN_W-1:0] size;
        logic [CW-1:0]  cnt;
        logic           started;
        logic           lng;
        logic [3:0]     errs;
        logic [1:0]     cls;
    } ctx_t;

    ctx_t q, d;

    logic [31:0]   status_word;
    logic [AW-1:0] lane_addr;
    logic [3:0]    lane_be;
    logic [31:0]   lane_wdata;

    rxd_status_pack u_pack (
        .cnt  (q.cnt),
        .size (q.size),
        .lng  (q.lng),
        .errs (q.errs),
        .cls  (q.cls),
        .word (status_word)
    );

    rxd_byte_lane #(.AW(AW)) u_lane (
        .base   (q.bufa),
        .offset (AW'(q.cnt)),
        .data   (fr_data),
        .addr   (lane_addr),
        .be     (lane_be),
        .wdata  (lane_wdata)
    );

    always_comb begin
        d         = q;
        fr_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = q.cur;
        mem_be    = 4'hF;
        mem_wdata = status_word;
        irq_done  = 1'b0;
        irq_err   = 1'b0;
        irq_nobuf = 1'b0;

        case (q.st)
            ST_HALT: begin
                if (desc_load) begin
                    d.cur = desc_addr;
                    d.st  = ST_RD_STAT;
                end
            end
            ST_RD_STAT: begin
                mem_req = 1'b1;
                d.st    = ST_CHK_OWN;
            end
            ST_CHK_OWN: begin
                if (mem_rdata[OWN_BIT]) begin
                    mem_req  = 1'b1;
                    mem_addr = q.cur + AW'(OFS_CTL);
                    d.st     = ST_CAP_CTL;
                end else begin
                    irq_nobuf = 1'b1;
                    d.st      = ST_WAIT_POLL;
                end
            end
            ST_CAP_CTL: begin
                d.size   = mem_rdata[LEN_W-1:0];
                mem_req  = 1'b1;
                mem_addr = q.cur + AW'(OFS_BUF);
                d.st     = ST_CAP_BUF;
            end
            ST_CAP_BUF: begin
                d.bufa   = mem_rdata[AW-1:0];
                mem_req  = 1'b1;
                mem_addr = q.cur + AW'(OFS_BR);
                d.st     = ST_CAP_BR;
            end
            ST_CAP_BR: begin
                d.br      = mem_rdata[AW-1:0];
                d.cnt     = '0;
                d.started = 1'b0;
                d.lng     = 1'b0;
                d.st      = ST_DATA;
            end
            ST_DATA: begin
                fr_ready = 1'b1;
                if (fr_valid && (q.started || fr_sof)) begin
                    d.started = 1'b1;
                    if ({1'b0, q.size} > q.cnt) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = lane_addr;
                        mem_be    = lane_be;
                        mem_wdata = lane_wdata;
                    end else begin
                        d.lng = 1'b1;
                    end
                    if (q.cnt != {CW{1'b1}}) d.cnt = q.cnt + 1'b1;
                    if (fr_eof) begin
                        d.errs = fr_err;
                        d.cls  = fr_cls;
                        d.st   = ST_WB;
                    end
                end
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (status_word[SUM_BIT]) irq_err = 1'b1;
                else                      irq_done = 1'b1;
                d.st = ST_NEXT;
            end
            ST_NEXT: begin
                if (q.br != '0) begin
                    d.cur = q.br;
                    d.st  = ST_RD_STAT;
                end else begin
                    irq_nobuf = 1'b1;
                    d.st      = ST_WAIT_LINK;
                end
            end
            ST_WAIT_POLL: begin
                if (desc_load) begin
                    d.cur = desc_addr;
                    d.st  = ST_RD_STAT;
                end else if (poll) begin
                    d.st = ST_RD_STAT;
                end
            end
            ST_WAIT_LINK: begin
                if (desc_load) begin
                    d.cur = desc_addr;
                    d.st  = ST_RD_STAT;
                end else if (poll) begin
                    mem_req  = 1'b1;
                    mem_addr = q.cur + AW'(OFS_BR);
                    d.st     = ST_CHK_LINK;
                end
            end
            ST_CHK_LINK: begin
                d.br = mem_rdata[AW-1:0];
                d.st = ST_NEXT;
            end
            default: d.st = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R9
    irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_done, irq_err, irq_nobuf}));

    // R9
    irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done || irq_err) |=> !(irq_done || irq_err));

    // R8
    status_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_done || irq_err) |-> (mem_req && mem_we && mem_be == 4'hF
                                   && mem_addr == q.cur && !mem_wdata[OWN_BIT]));

    // R4
    lane_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_be != 4'hF) |-> ($onehot(mem_be) && mem_addr[1:0] == 2'b00));

    // R3
    stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_nobuf |=> !fr_ready);

endmodule

// File: tb/rxd_ring_writer_tb.sv
`timescale 1ns/1ps
module rxd_ring_writer_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          desc_load = 1'b0;
    logic [AW-1:0] desc_addr = '0;
    logic          poll = 1'b0;
    logic          fr_valid = 1'b0;
    logic          fr_ready;
    logic [7:0]    fr_data = '0;
    logic          fr_sof = 1'b0;
    logic          fr_eof = 1'b0;
    logic [3:0]    fr_err = '0;
    logic [1:0]    fr_cls = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;
    logic          irq_done, irq_err, irq_nobuf;

    logic [31:0] mem [0:1023];
    logic        hw_en = 1'b0;
    logic [9:0]  hw_idx = '0;
    logic [31:0] hw_data = '0;
    logic [7:0]  sent [0:255];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    rxd_ring_writer #(.AW(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .desc_load(desc_load), .desc_addr(desc_addr),
        .poll(poll), .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data),
        .fr_sof(fr_sof), .fr_eof(fr_eof), .fr_err(fr_err), .fr_cls(fr_cls),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .irq_done(irq_done), .irq_err(irq_err), .irq_nobuf(irq_nobuf)
    );

    always @(posedge clk) begin
        if (hw_en) mem[hw_idx] <= hw_data;
        if (mem_req) begin
            if (mem_we) begin
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) mem[mem_addr[11:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
            end else begin
                mem_rdata <= mem[mem_addr[11:2]];
            end
        end
    end

    function automatic logic [7:0] mbyte(input int a);
        logic [31:0] w;
        w = mem[a[11:2]];
        return w[8*a[1:0] +: 8];
    endfunction

    function automatic logic [31:0] exp_status(input int n, input int size,
                                               input logic [1:0] cls, input logic [3:0] er);
        logic [31:0] s;
        logic lng;
        lng = (n > size);
        s = '0;
        s[26:16] = 11'(lng ? size : n);
        s[1] = er[0]; s[2] = er[1]; s[3] = er[2]; s[5] = er[3];
        s[4] = lng;
        s[0] = (|er) | lng;
        s[15] = ~s[0];
        s[9] = 1'b1; s[8] = 1'b1;
        if (cls == 2'd1) s[11] = 1'b1;
        if (cls == 2'd2) s[12] = 1'b1;
        if (cls == 2'd3) s[13] = 1'b1;
        return s;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_wr(input int a, input logic [31:0] v);
        hw_en = 1'b1; hw_idx = a[11:2]; hw_data = v;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic set_desc(input int da, input logic own, input int size, input int ba, input int br);
        host_wr(da,      own ? 32'h8000_0000 : 32'h0);
        host_wr(da + 4,  size);
        host_wr(da + 8,  ba);
        host_wr(da + 12, br);
    endtask

    task automatic wait_irq(output logic [2:0] seen);
        int g = 0;
        while (!(irq_done || irq_err || irq_nobuf) && g < 3000) begin
            @(negedge clk); g++;
        end
        seen = {irq_done, irq_err, irq_nobuf};
    endtask

    task automatic send_frame(input int n, input int junk, input logic [1:0] cls, input logic [3:0] er);
        for (int i = 0; i < junk + n; i++) begin
            int g = 0;
            fr_valid = 1'b1;
            fr_data  = (i < junk) ? 8'hEE : sent[i - junk];
            fr_sof   = (i == junk);
            fr_eof   = (i == junk + n - 1);
            fr_err   = fr_eof ? er : 4'h0;
            fr_cls   = fr_eof ? cls : 2'd0;
            while (!fr_ready && g < 3000) begin
                @(negedge clk); g++;
            end
            @(negedge clk);
        end
        fr_valid = 1'b0; fr_sof = 1'b0; fr_eof = 1'b0; fr_err = '0; fr_cls = '0;
    endtask

    task automatic frame_and_check(input int da, input int ba, input int size, input int n,
                                   input int junk, input logic [1:0] cls, input logic [3:0] er);
        logic [2:0] seen;
        logic lng;
        int stored, bad;
        lng = (n > size);
        stored = lng ? size : n;
        for (int i = 0; i < n; i++) sent[i] = 8'($urandom);
        send_frame(n, junk, cls, er);
        wait_irq(seen);
        // R8: status write is a full word to the descriptor in the interrupt cycle
        chk("R8 status write port", {mem_req, mem_we, mem_be, 16'(mem_addr)},
            {1'b1, 1'b1, 4'hF, 16'(da)});
        // R9: interrupt kind follows the error summary
        chk("R9 irq kind", {29'b0, seen}, {29'b0, ((|er) | lng) ? 3'b010 : 3'b100});
        @(negedge clk);
        // R5 R6: packed status word
        chk("R5 R6 status word", mem[da[11:2]], exp_status(n, size, cls, er));
        bad = 0;
        for (int i = 0; i < stored; i++) if (mbyte(ba + i) !== sent[i]) bad++;
        // R2 R4 R11: bytes at buffer+k
        chk("R2 R4 R11 buffer bytes", bad, 0);
        // R7: nothing written past the stored bytes
        chk("R7 byte after data", {24'b0, mbyte(ba + stored)}, 32'hA5);
    endtask

    initial begin
        logic [2:0] seen;
        int seen_ready;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R1: reset state
        chk("R1 reset outputs", {27'b0, fr_ready, mem_req, irq_done, irq_err, irq_nobuf}, 32'h0);
        rst_n = 1'b1;
        for (int w = 0; w < 1024; w++) host_wr(w * 4, 32'hA5A5_A5A5);
        // R1: still halted without a descriptor address
        chk("R1 halted before load", {29'b0, fr_ready, mem_req, irq_nobuf}, 32'h0);

        for (int k = 0; k < 6; k++) set_desc(k * 16, 1'b1, 96, 32'h100 + k * 32'h80, (k + 1) * 16);
        set_desc(6 * 16, 1'b1, 8,  32'h100 + 6 * 32'h80, 7 * 16);
        set_desc(7 * 16, 1'b1, 96, 32'h100 + 7 * 32'h80 + 3, 8 * 16);
        set_desc(8 * 16, 1'b0, 96, 32'h100 + 8 * 32'h80, 0);
        set_desc(9 * 16, 1'b1, 96, 32'h100 + 9 * 32'h80 + 2, 0);

        desc_load = 1'b1; desc_addr = '0;
        @(negedge clk);
        desc_load = 1'b0;

        for (int k = 0; k < 6; k++) begin
            int n;
            logic [1:0] cls;
            logic [3:0] er;
            n   = 1 + int'($urandom % 110);
            cls = 2'($urandom);
            er  = ($urandom % 3 == 0) ? 4'($urandom) : 4'h0;
            frame_and_check(k * 16, 32'h100 + k * 32'h80, 96, n, 0, cls, er);
        end
        // R7: truncation on an 8-byte buffer
        frame_and_check(6 * 16, 32'h100 + 6 * 32'h80, 8, 12, 0, 2'd2, 4'h0);
        // R11 R4: junk before start, odd buffer address
        frame_and_check(7 * 16, 32'h100 + 7 * 32'h80 + 3, 96, 20, 3, 2'd1, 4'h0);

        // R3: next descriptor not owned
        wait_irq(seen);
        chk("R3 nobuf on unowned", {29'b0, seen}, 32'h1);
        fr_valid = 1'b1; fr_sof = 1'b1; fr_data = 8'h11;
        seen_ready = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (fr_ready) seen_ready++;
        end
        host_wr(8 * 16, 32'h8000_0000);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (fr_ready) seen_ready++;
        end
        chk("R3 stalled until poll", seen_ready, 0);
        chk("R3 status untouched while stalled", mem[8 * 16 / 4], 32'h8000_0000);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        frame_and_check(8 * 16, 32'h100 + 8 * 32'h80, 96, 30, 0, 2'd3, 4'h0);

        // R10: zero branch ends the chain
        wait_irq(seen);
        chk("R10 nobuf on zero branch", {29'b0, seen}, 32'h1);
        repeat (5) @(negedge clk);
        chk("R10 stalled at chain end", {31'b0, fr_ready}, 32'h0);
        host_wr(8 * 16 + 12, 9 * 16);
        poll = 1'b1;
        @(negedge clk);
        poll = 1'b0;
        // R6: directed error mix
        frame_and_check(9 * 16, 32'h100 + 9 * 32'h80 + 2, 96, 64, 0, 2'd0, 4'b1010);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule